// File: doc/BRIEF.md
# Byte-Addressed Parallel NOR Flash Read Adapter

This block connects a byte-addressed processor read port to an external asynchronous parallel NOR flash device. The processor sees flat byte addresses and asks for a byte, a halfword or a word. The flash only holds whole words of its own data-bus width. The adapter drops the low CPU address bits that select a byte inside a flash word, and drives the remaining bits as the flash address. It also drives the active-low chip-enable and output-enable strobes and counts out the access time. It then either selects the wanted byte lane or joins several flash beats into one 32-bit result.

The flash data width is a parameter: 8, 16 or 32 bits. For a 16-bit device, CPU address bit 1 lands on flash address line 0. For an 8-bit device the shift is zero, and for a 32-bit device it is two. Requests use a valid/ready handshake. The reply is a one-cycle valid pulse carrying the data, or an error flag when the request is misaligned.

Top module: `nor_rd_adapter`

## Requirements
- R1: The flash address driven during a read equals the CPU byte address shifted right by log2(FLASH_W/8). With the default 16-bit flash this is address bits 20:1 placed on the 20 flash address lines.
- R2: A byte read (size code 2'b00) at an even address returns bits 7:0 of the addressed 16-bit flash word, zero-extended to 32 bits.
- R3: A byte read at an odd address returns bits 15:8 of the same flash word, zero-extended. The flash address is the same as for the even neighbour.
- R4: A halfword read (size code 2'b01) at an even address returns the whole 16-bit flash word, zero-extended.
- R5: A word read (size code 2'b10) with address bits 1:0 zero performs two flash reads. The first is at halfword address A and supplies result bits 15:0. The second is at A+1 and supplies bits 31:16.
- R6: Every flash read holds chip-enable and output-enable low for exactly WAIT_CYC consecutive cycles with a stable address. The data is taken on the last of those cycles.
- R7: Output-enable returns high for at least one cycle between two flash reads of one request.
- R8: A halfword request with address bit 0 set, a word request with address bits 1:0 nonzero, or size code 2'b11 gets a response with the error flag set and data zero. No flash cycle is issued, and the response arrives one cycle after acceptance.
- R9: The response valid signal is high for exactly one cycle. For a good request it arrives beats*WAIT_CYC + beats cycles after acceptance. Ready is low from acceptance until the response has been given.
- R10: Out of reset, and whenever the adapter is idle, ready is high, both flash strobes are high and response valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Adapter can take a request |
| req_addr | input | CPU_AW | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Zero-extended read result |
| rsp_err | output | 1 | Misaligned or invalid request |
| fl_addr | output | CPU_AW-log2(FLASH_W/8) | Flash word address |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_data | input | FLASH_W | Flash read data |

## Verification
The bench builds the adapter with the defaults: a 16-bit flash, a 21-bit CPU address and three wait cycles. With these values it reaches the even/odd byte-lane choice and the two-beat word merge, including the beat at the highest flash address. Three wait cycles also let the flash model drive garbage before the last cycle of each access, so data taken early is detected. Run lengths of the strobes and the addresses seen at each falling edge are checked per request. The 8-bit and 32-bit variants are covered by the same generic shift and lane logic, but only elaborated.

// File: rtl/nor_rd_adapter.sv
module nor_rd_adapter #(
  parameter int FLASH_W  = 16,
  parameter int CPU_AW   = 21,
  parameter int WAIT_CYC = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [CPU_AW-1:0]                     req_addr,
  input  logic [1:0]                            req_size,
  output logic                                  rsp_valid,
  output logic [31:0]                           rsp_data,
  output logic                                  rsp_err,
  output logic [CPU_AW-$clog2(FLASH_W/8)-1:0]   fl_addr,
  output logic                                  fl_ce_n,
  output logic                                  fl_oe_n,
  input  logic [FLASH_W-1:0]                    fl_data
);
  localparam int FB   = FLASH_W / 8;
  localparam int SH   = $clog2(FB);
  localparam int FA_W = CPU_AW - SH;
  localparam int WW   = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_GAP, S_DONE} st_t;

  st_t             st;
  logic [FA_W-1:0] fa;
  logic [WW-1:0]   wcnt;
  logic [2:0]      beat, beats;
  logic [1:0]      size_q, lane_q;
  logic            err_q;
  logic [31:0]     acc;

  logic [2:0]  nbytes, nbeats;
  logic        bad;
  logic        last_wait, last_beat;
  logic [31:0] shifted, mask;

  always_comb begin
    case (req_size)
      2'b00:   nbytes = 3'd1;
      2'b01:   nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
    nbeats = nbytes >> SH;
    if (nbeats == 3'd0) nbeats = 3'd1;
  end

  assign bad = (req_size == 2'b11)
            || (req_size == 2'b01 && req_addr[0])
            || (req_size == 2'b10 && req_addr[1:0] != 2'b00);

  assign last_wait = (wcnt == WW'(WAIT_CYC - 1));
  assign last_beat = (beat == beats - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      fa     <= '0;
      wcnt   <= '0;
      beat   <= '0;
      beats  <= 3'd1;
      size_q <= '0;
      lane_q <= '0;
      err_q  <= 1'b0;
      acc    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          size_q <= req_size;
          lane_q <= req_addr[1:0] & 2'(FB - 1);
          acc    <= '0;
          beat   <= '0;
          wcnt   <= '0;
          beats  <= nbeats;
          fa     <= req_addr[CPU_AW-1:SH];
          err_q  <= bad;
          st     <= bad ? S_DONE : S_ACT;
        end
        S_ACT: begin
          if (last_wait) begin
            acc  <= acc | (32'(fl_data) << (32'(beat) * FLASH_W));
            wcnt <= '0;
            if (last_beat) st <= S_DONE;
            else begin
              beat <= beat + 3'd1;
              fa   <= fa + FA_W'(1);
              st   <= S_GAP;
            end
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        S_GAP:  st <= S_ACT;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign shifted = acc >> {lane_q, 3'b000};

  always_comb begin
    case (size_q)
      2'b00:   mask = 32'h0000_00FF;
      2'b01:   mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_data  = (rsp_valid && !err_q) ? (shifted & mask) : 32'h0;
  assign fl_addr   = fa;
  assign fl_ce_n   = (st != S_ACT);
  assign fl_oe_n   = (st != S_ACT);
endmodule

module nor_rd_adapter_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [31:0]   rsp_data,
  input logic [AW-1:0] fl_addr,
  input logic          fl_ce_n,
  input logic          fl_oe_n
);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n && $past(!fl_oe_n)) |-> $stable(fl_addr));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_data == 32'h0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_oe_n && !rsp_valid));
endmodule

bind nor_rd_adapter nor_rd_adapter_chk #(.AW(FA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n)
);

// File: tb/nor_rd_adapter_tb.sv
module nor_rd_adapter_tb_top;
  localparam int FW = 16, AW = 21, WT = 3, FAW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic [FAW-1:0] fl_addr;
  logic fl_ce_n, fl_oe_n;
  logic [FW-1:0] fl_data;
  int lowcnt = 0;
  int errors = 0, total = 0;

  always #5 clk = ~clk;

  nor_rd_adapter #(.FLASH_W(FW), .CPU_AW(AW), .WAIT_CYC(WT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .fl_addr(fl_addr),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_data(fl_data));

  function automatic logic [15:0] fmem(logic [FAW-1:0] a);
    logic [31:0] x = 32'(a) * 32'h9E37 + 32'h1D2B;
    return x[15:0] ^ 16'(a >> 3);
  endfunction

  always @(posedge clk) lowcnt <= (!fl_oe_n && !fl_ce_n) ? lowcnt + 1 : 0;
  assign fl_data = (!fl_oe_n && !fl_ce_n && lowcnt >= WT - 1) ? fmem(fl_addr) : 16'hBAD0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_rd(logic [AW-1:0] a, logic [1:0] sz);
    logic bad;
    logic [FAW-1:0] fa;
    logic [15:0] w;
    logic [31:0] exp;
    int beats, lat, n, runs, runlen;
    logic [FAW-1:0] seen [4];
    int lens [4];
    logic prev_oe;
    string tag;
    bad = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    fa = a[AW-1:1];
    w = fmem(fa);
    beats = (sz == 2'b10) ? 2 : 1;
    case (sz)
      2'b00: begin exp = a[0] ? {24'h0, w[15:8]} : {24'h0, w[7:0]}; tag = a[0] ? "R3" : "R2"; end
      2'b01: begin exp = {16'h0, w}; tag = "R4"; end
      default: begin exp = {fmem(fa + 20'd1), w}; tag = "R5"; end
    endcase
    if (bad) begin exp = 32'h0; beats = 0; lat = 1; tag = "R8"; end
    else lat = beats * WT + beats;

    req_addr = a; req_size = sz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; runs = 0; runlen = 0; prev_oe = 1'b1;
    chk(!req_ready, "R9", 64'(req_ready), 64'd0);
    while (!rsp_valid && n < 40) begin
      if (!fl_oe_n) begin
        if (prev_oe) begin
          if (runs < 4) seen[runs] = fl_addr;
          runs++; runlen = 0;
        end
        runlen++;
      end else if (!prev_oe && runs <= 4) lens[runs-1] = runlen;
      prev_oe = fl_oe_n;
      @(negedge clk); n++;
    end
    if (!prev_oe && runs > 0 && runs <= 4) lens[runs-1] = runlen;
    chk(rsp_valid && n == lat, "R9", 64'(n), 64'(lat));
    chk(rsp_err == bad, bad ? "R8" : tag, 64'(rsp_err), 64'(bad));
    chk(rsp_data == exp, tag, 64'(rsp_data), 64'(exp));
    chk(runs == beats, bad ? "R8" : "R7", 64'(runs), 64'(beats));
    for (int i = 0; i < runs && i < beats; i++) begin
      chk(seen[i] == fa + FAW'(i), (i == 0) ? "R1" : "R5", 64'(seen[i]), 64'(fa + FAW'(i)));
      chk(lens[i] == WT, "R6", 64'(lens[i]), 64'(WT));
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready && fl_oe_n && fl_ce_n, "R10",
        {61'h0, rsp_valid, req_ready, fl_oe_n}, 64'b011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && fl_ce_n && fl_oe_n && !rsp_valid, "R10",
        {60'h0, req_ready, fl_ce_n, fl_oe_n, rsp_valid}, 64'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    do_rd(21'h0, 2'b00);
    do_rd(21'h1, 2'b00);
    do_rd(21'h2, 2'b00);
    do_rd(21'h3, 2'b00);
    do_rd(21'h0, 2'b01);
    do_rd(21'h3, 2'b01);
    do_rd(21'h4, 2'b10);
    do_rd(21'h6, 2'b10);
    do_rd(21'h5, 2'b10);
    do_rd(21'h8, 2'b11);
    do_rd(21'h1F_FFFC, 2'b10);
    do_rd(21'h1F_FFFF, 2'b00);
    do_rd(21'h1F_FFFE, 2'b01);
    for (int i = 0; i < 400; i++) begin
      a = AW'($urandom);
      if ($urandom % 10 < 7) a[1:0] = 2'b00;
      do_rd(a, 2'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule